// File: doc/BRIEF.md
# Two-stage programmable clock divider

The block derives a slower clock from an input clock through two cascaded counting stages. A prescaler divides by a mantissa taken from a fixed set of eight values, some of which are not powers of two. A chain of digit counters then divides further by a power of a configurable base, which is ten by default. A test input removes three digits from the chain so that long ratios can be exercised quickly. The second output always carries an ungated copy of the input clock.

The divider input is either the input clock or an external clock, picked by a select line. The select line is only changed while the block is held in reset. The active-low reset stops the divided output at once. Its release is re-timed to the divider input clock, so the first output period starts a fixed number of edges after release. Any change to the ratio controls is held back until the running period ends, so a retune never produces a shortened pulse. When the total ratio is one, the output is the divider input clock gated by the run state. The parameter `DEC_BASE` must be even and at least 2.

Top module: `prog_clk_div`

## Requirements
- R1: The prescaler ratio M is selected by `pre_sel_i` as follows: 3'b000 gives 1, 3'b001 gives 10, 3'b010 gives 2, 3'b011 gives 3, 3'b100 gives 4, 3'b101 gives 5, 3'b110 gives 6 and 3'b111 gives 12.
- R2: The chain exponent e equals the unsigned value of `dec_sel_i`. Bit 0 adds one digit, bit 1 adds two digits and bit 2 adds four digits. The total ratio is N = M * DEC_BASE^e.
- R3: When `test_i` is high and `dec_sel_i[2]` is high, e is reduced by 3. When `dec_sel_i[2]` is low, `test_i` has no effect.
- R4: For N >= 2 the output is high for the first floor(N/2) divider-input cycles of each N-cycle period and low for the rest. An even N therefore gives 50% duty, and an odd N gives a low phase one cycle longer than the high phase.
- R5: When N = 1, the output equals the divider input clock ANDed with the run state.
- R6: While `rst_ni` is low the output is low and all counters are cleared, with no clock needed. After release, the run state becomes true on the `SYNC_STAGES`-th divider-input rising edge. The counted output rises one edge later, or on that same edge when N = 1.
- R7: New values on `pre_sel_i`, `dec_sel_i` and `test_i` are taken only at the last cycle of a running period, or on any edge while the block is not running. The current period always completes with the old ratio.
- R8: With `ext_sel_i` high the divider runs from `ext_clk_i`. With `ext_sel_i` low, activity on `ext_clk_i` has no effect on the output.
- R9: `src_clk_o` always equals `clk_i`, regardless of every other input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset, releases the output |
| ext_clk_i | input | 1 | External clock |
| ext_sel_i | input | 1 | High selects the external clock as divider input |
| pre_sel_i | input | 3 | Prescaler ratio select |
| dec_sel_i | input | 3 | Digit-chain exponent select |
| test_i | input | 1 | Removes three digits when dec_sel_i[2] is high |
| div_clk_o | output | 1 | Divided clock |
| src_clk_o | output | 1 | Ungated copy of clk_i |

## Verification
A prescaler or digit counter that holds a wrong count moves the output's rising or falling edge, and the cycle-accurate model catches this within the same output period. A configuration register that loads in mid-period shows up as a period of mixed length, visible at the first boundary after the control change. A wrong reset synchroniser depth or a missed clear shows up as a first output edge one or more cycles early or late after release.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int unsigned SEL_W      = 3;
  localparam int unsigned MANT_W     = 4;
  localparam int unsigned EXP_W      = SEL_W;
  localparam int unsigned DEC_STAGES = (1 << SEL_W) - 1;
  localparam int unsigned TEST_SKIP  = 3;

  typedef struct packed {
    logic [MANT_W-1:0] mant;
    logic [EXP_W-1:0]  exp;
  } div_cfg_t;

  localparam div_cfg_t CFG_RESET = '{mant: MANT_W'(1), exp: '0};

  // non-monotonic mantissa encoding
  function automatic logic [MANT_W-1:0] mant_of(input logic [SEL_W-1:0] sel);
    logic [MANT_W-1:0] m;
    unique case (sel)
      3'b000:  m = MANT_W'(1);
      3'b001:  m = MANT_W'(10);
      3'b010:  m = MANT_W'(2);
      3'b011:  m = MANT_W'(3);
      3'b100:  m = MANT_W'(4);
      3'b101:  m = MANT_W'(5);
      3'b110:  m = MANT_W'(6);
      default: m = MANT_W'(12);
    endcase
    return m;
  endfunction

  // dsel weights 4/2/1 equal its binary value; test drops three digits
  function automatic logic [EXP_W-1:0] exp_of(input logic [SEL_W-1:0] dsel,
                                              input logic             test);
    logic [EXP_W-1:0] e;
    e = dsel;
    if (test && dsel[SEL_W-1]) e = e - EXP_W'(TEST_SKIP);
    return e;
  endfunction

endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic run_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES:0]   chain;

  assign chain = {sync_q, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= chain[STAGES-1:0];
  end

  assign run_o = sync_q[STAGES-1];

endmodule

// File: rtl/clkdiv_prescale.sv
module clkdiv_prescale #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] ratio_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);

  logic [W-1:0] cnt_q;

  assign last_o = (cnt_q == ratio_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/clkdiv_digit_chain.sv
module clkdiv_digit_chain #(
  parameter int unsigned BASE   = 10,
  parameter int unsigned STAGES = 7,
  localparam int unsigned DW    = (BASE > 2) ? $clog2(BASE) : 1,
  localparam int unsigned EW    = $clog2(STAGES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [EW-1:0] exp_i,
  output logic          last_o,
  output logic          top_low_o
);

  localparam logic [DW-1:0] DIG_MAX  = DW'(BASE - 1);
  localparam logic [DW-1:0] DIG_HALF = DW'(BASE / 2);

  logic [DW-1:0]     dig_q [STAGES];
  logic [STAGES-1:0] act;
  logic [STAGES-1:0] at_max;
  logic [STAGES-1:0] done;
  logic [STAGES:0]   carry;

  assign carry[0] = step_i;

  for (genvar g = 0; g < STAGES; g++) begin : g_dig
    assign act[g]      = (EW'(g) < exp_i);
    assign at_max[g]   = (dig_q[g] == DIG_MAX);
    assign done[g]     = at_max[g] | ~act[g];
    assign carry[g+1]  = carry[g] & done[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 dig_q[g] <= '0;
      else if (clr_i)              dig_q[g] <= '0;
      else if (act[g] && carry[g]) dig_q[g] <= at_max[g] ? '0 : dig_q[g] + DW'(1);
    end
  end

  assign last_o = &done;

  // most significant active digit in lower half -> first half of the period
  always_comb begin
    top_low_o = 1'b0;
    for (int k = 0; k < STAGES; k++) begin
      if (EW'(k + 1) == exp_i) top_low_o = (dig_q[k] < DIG_HALF);
    end
  end

endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div
  import clkdiv_pkg::*;
#(
  parameter int unsigned DEC_BASE    = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             ext_sel_i,
  input  logic [SEL_W-1:0] pre_sel_i,
  input  logic [SEL_W-1:0] dec_sel_i,
  input  logic             test_i,
  output logic             div_clk_o,
  output logic             src_clk_o
);

  logic              div_clk;
  logic              run;
  div_cfg_t          cfg_d, cfg_q;
  logic [MANT_W-1:0] pre_cnt;
  logic              pre_last;
  logic              dec_last;
  logic              dec_top_low;
  logic              period_end;
  logic              high;
  logic              out_q;
  logic              bypass;

  // select changes only under reset
  assign div_clk = ext_sel_i ? ext_clk_i : clk_i;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (div_clk),
    .rst_ni (rst_ni),
    .run_o  (run)
  );

  assign cfg_d = '{mant: mant_of(pre_sel_i), exp: exp_of(dec_sel_i, test_i)};

  clkdiv_prescale #(.W(MANT_W)) u_pre (
    .clk_i   (div_clk),
    .rst_ni  (rst_ni),
    .clr_i   (~run),
    .ratio_i (cfg_q.mant),
    .cnt_o   (pre_cnt),
    .last_o  (pre_last)
  );

  clkdiv_digit_chain #(.BASE(DEC_BASE), .STAGES(DEC_STAGES)) u_dec (
    .clk_i     (div_clk),
    .rst_ni    (rst_ni),
    .clr_i     (~run),
    .step_i    (run & pre_last),
    .exp_i     (cfg_q.exp),
    .last_o    (dec_last),
    .top_low_o (dec_top_low)
  );

  assign period_end = run & pre_last & dec_last;

  always_ff @(posedge div_clk or negedge rst_ni) begin
    if (!rst_ni)                 cfg_q <= CFG_RESET;
    else if (!run || period_end) cfg_q <= cfg_d;
  end

  always_comb begin
    if (cfg_q.exp == '0) high = (pre_cnt < (cfg_q.mant >> 1));
    else                 high = dec_top_low;
  end

  always_ff @(posedge div_clk or negedge rst_ni) begin
    if (!rst_ni) out_q <= 1'b0;
    else         out_q <= run & high;
  end

  assign bypass    = (cfg_q.mant == MANT_W'(1)) && (cfg_q.exp == '0);
  assign div_clk_o = bypass ? (div_clk & run) : out_q;
  assign src_clk_o = clk_i;

endmodule

// File: rtl/prog_clk_div_chk.sv
module prog_clk_div_chk
  import clkdiv_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              period_end_i,
  input logic [MANT_W-1:0] cfg_m_i,
  input logic [EXP_W-1:0]  cfg_e_i,
  input logic [MANT_W-1:0] pre_cnt_i,
  input logic              out_q_i,
  input logic              div_o_i
);

  assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !period_end_i) |=> ($stable(cfg_m_i) && $stable(cfg_e_i)));

  assert_pre_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt_i < cfg_m_i);

  assert_wrap_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_end_i |=> (pre_cnt_i == '0));

  assert_idle_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !out_q_i);

  assert_reset_low_R6: assert property (@(posedge clk_i)
    !rst_ni |-> !div_o_i);

endmodule

bind prog_clk_div prog_clk_div_chk u_chk (
  .clk_i        (div_clk),
  .rst_ni       (rst_ni),
  .run_i        (run),
  .period_end_i (period_end),
  .cfg_m_i      (cfg_q.mant),
  .cfg_e_i      (cfg_q.exp),
  .pre_cnt_i    (pre_cnt),
  .out_q_i      (out_q),
  .div_o_i      (div_clk_o)
);

// File: tb/prog_clk_div_test.sv
`timescale 1ns/1ps
module prog_clk_div_test;

  localparam int BASE     = 2;
  localparam int SYNC     = 2;
  localparam int EXT_HALF = 11;
  localparam int WD_NS    = 1_200_000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ext_sel = 1'b0;
  logic [2:0] pre = 3'b000;
  logic [2:0] dec = 3'b000;
  logic       tst = 1'b0;
  logic       div_o;
  logic       src_o;

  int    total = 0;
  int    bad = 0;
  bit    model_on = 1'b1;
  bit    done = 1'b0;
  string cur_tag = "R6";

  always #4 clk_i = ~clk_i;
  always #(EXT_HALF) ext_clk = ~ext_clk;

  prog_clk_div #(.DEC_BASE(BASE), .SYNC_STAGES(SYNC)) uut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_clk_i (ext_clk),
    .ext_sel_i (ext_sel),
    .pre_sel_i (pre),
    .dec_sel_i (dec),
    .test_i    (tst),
    .div_clk_o (div_o),
    .src_clk_o (src_o)
  );

  function automatic int ref_n(input logic [2:0] p, input logic [2:0] d, input logic t);
    int m;
    int e;
    case (p)
      3'd0: m = 1;  3'd1: m = 10; 3'd2: m = 2; 3'd3: m = 3;
      3'd4: m = 4;  3'd5: m = 5;  3'd6: m = 6; default: m = 12;
    endcase
    e = int'(d);
    if (t && d[2]) e = e - 3;
    return m * (BASE ** e);
  endfunction

  task automatic check(input string tag, input logic got, input logic want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s t=%0t got=%b exp=%b", tag, $time, got, want);
    end
  endtask

  // behavioural reference model
  int m_rel, m_cnt, m_n;
  bit m_run, m_outq;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_rel = 0; m_run = 0; m_cnt = 0; m_n = 1; m_outq = 0;
    end else begin
      m_outq = m_run && (m_cnt < m_n / 2);
      if (!m_run) begin
        m_cnt = 0; m_n = ref_n(pre, dec, tst);
      end else if (m_cnt == m_n - 1) begin
        m_cnt = 0; m_n = ref_n(pre, dec, tst);
      end else begin
        m_cnt++;
      end
      if (m_rel < SYNC) m_rel++;
      m_run = (m_rel >= SYNC);
    end
  end

  always @(posedge clk_i) begin
    #2;
    if (model_on && !done) begin
      check(cur_tag, div_o, (m_n == 1) ? m_run : m_outq);
      check("R9", src_o, 1'b1);
    end
  end

  always @(negedge clk_i) begin
    #2;
    if (model_on && !done) check("R9", src_o, 1'b0);
  end

  task automatic run_setting(input logic [2:0] p, input logic [2:0] d,
                             input logic t, input string tag);
    @(negedge clk_i);
    rst_ni = 1'b0; pre = p; dec = d; tst = t; cur_tag = tag;
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2 * ref_n(p, d, t) + SYNC + 4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(WD_NS);
    bad++;
    $display("FAIL watchdog t=%0t", $time);
    finish_run();
  end

  initial begin
    realtime t0, t1, t2;
    // R6: reset state
    repeat (3) @(negedge clk_i);
    check("R6", div_o, 1'b0);

    // R1 R2 R4 R5: every ratio setting with the full chain
    for (int s = 0; s < 64; s++)
      run_setting(3'(s >> 3), 3'(s), 1'b0, "R1/R2/R4/R5");

    // R3: shortened chain, and no effect without the top select bit
    for (int s = 0; s < 32; s++)
      run_setting(3'(s >> 2), {1'b1, 2'(s)}, 1'b1, "R3");
    run_setting(3'b111, 3'b011, 1'b1, "R3");
    run_setting(3'b011, 3'b001, 1'b1, "R3");

    // R7: retune mid-period without reset
    run_setting(3'b111, 3'b001, 1'b0, "R7");
    cur_tag = "R7";
    repeat (5) @(negedge clk_i);
    pre = 3'b010; dec = 3'b000;
    repeat (40) @(negedge clk_i);
    pre = 3'b000;
    repeat (12) @(negedge clk_i);
    pre = 3'b101;
    repeat (33) @(negedge clk_i);
    pre = 3'b100; dec = 3'b101; tst = 1'b1;
    repeat (3) @(negedge clk_i);
    tst = 1'b0;
    repeat (140) @(negedge clk_i);

    // R6: async stop while high
    @(negedge clk_i);
    rst_ni = 1'b0; pre = 3'b111; dec = 3'b001; tst = 1'b0; cur_tag = "R6";
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (SYNC + 2) @(negedge clk_i);
    check("R4", div_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R6", div_o, 1'b0);
    repeat (3) @(negedge clk_i);

    // R8: external clock, divide by 4
    model_on = 1'b0;
    ext_sel = 1'b1; pre = 3'b100; dec = 3'b000;
    #50;
    rst_ni = 1'b1;
    repeat (SYNC + 3) @(posedge ext_clk);
    @(posedge div_o); t0 = $realtime;
    @(negedge div_o); t1 = $realtime;
    @(posedge div_o); t2 = $realtime;
    total++;
    if (t2 - t0 != 8.0 * EXT_HALF) begin
      bad++; $display("FAIL R8 period got=%0t exp=%0d", t2 - t0, 8 * EXT_HALF);
    end
    total++;
    if (t1 - t0 != 4.0 * EXT_HALF) begin
      bad++; $display("FAIL R8 high got=%0t exp=%0d", t1 - t0, 4 * EXT_HALF);
    end
    @(posedge clk_i); #2;
    check("R9", src_o, 1'b1);

    // R8 R5: external clock passed through
    rst_ni = 1'b0; pre = 3'b000;
    #30;
    rst_ni = 1'b1;
    repeat (SYNC + 3) @(posedge ext_clk);
    #3;
    check("R8", div_o, 1'b1);
    @(negedge ext_clk); #3;
    check("R8", div_o, 1'b0);

    // back to the input clock
    @(negedge clk_i);
    rst_ni = 1'b0; ext_sel = 1'b0;
    @(negedge clk_i);
    model_on = 1'b1;
    run_setting(3'b011, 3'b000, 1'b0, "R8");
    run_setting(3'b000, 3'b000, 1'b0, "R8");

    finish_run();
  end

endmodule